// File: doc/BRIEF.md
# Synthesizer Divider Serial Loader

This block programs an external frequency synthesizer once after reset. It drives a three-wire serial link made of a serial clock, a data line and a latch-enable line. First it waits for a power-up delay, which is counted in serial-clock periods. It then sends two fixed divide ratios: the reference divider first and the comparison divider second. The serial clock is a slow clock, roughly 700 Hz by default, made by dividing the system clock.

Each frame carries 18 serial clocks. The first 16 slots carry the 16-bit ratio, most significant bit first. The 17th slot carries a control bit that tells the synthesizer which divider the frame targets. The 18th slot raises latch-enable so that the synthesizer loads the word. After the second frame the serial clock stops and a done flag stays high until the next reset.

Top module: `syn_div_loader`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it is released, the serial clock, data, latch-enable and done outputs are all low.
- R2: With a half-period of H system clocks and a delay parameter D, the first rising edge of the serial clock follows the (2D+3)·H-th system clock edge after reset release.
- R3: While frames are being sent, successive serial-clock rising edges are exactly 2·H system clocks apart, with no gap at the boundary between frames.
- R4: The first frame carries the reference ratio (default 1000). Its bits are sampled on serial-clock rising edges from bit 15 down to bit 0.
- R5: The 17th bit of a frame is the control bit: 1 in the reference frame and 0 in the comparison frame.
- R6: In the 18th serial-clock slot of each frame, latch-enable is high and data is low. In every other slot latch-enable is low.
- R7: The second frame carries the comparison ratio (default 59650) in the same order and format as the first.
- R8: Data and latch-enable change only while the serial clock is low. They stay steady while the serial clock is high.
- R9: After the latch-enable slot of the second frame, the serial clock makes no further rising edges, data and latch-enable stay low, and done stays high until reset.
- R10: A reset after completion restarts the whole sequence, and the sequence repeats identically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_o | output | 1 | Serial clock to the synthesizer |
| ser_data_o | output | 1 | Serial data, sampled by the synthesizer on the rising serial clock |
| ser_le_o | output | 1 | Latch-enable pulse, one per frame |
| done_o | output | 1 | High once both frames are loaded |

## Verification
The bench runs the block with a small clock divider and a short delay. A scoreboard is filled with the 36 expected (latch-enable, data) pairs for the two ratios. Every bit is compared against its entry at each serial-clock rising edge. The two ratios have different bit patterns and the control bit has opposite values in the two frames, so a swapped frame order, a reversed bit order or an inverted control bit each produce mismatches at separate positions. Timing is checked at three points: the arrival time of the first edge, the edge-to-edge spacing across the frame boundary, and the silence after done. A second run after reset confirms that the sequence restarts identically.

// File: rtl/syn_div_loader.sv
module syn_div_loader #(
  parameter int CLK_HZ        = 50_000_000,
  parameter int SCLK_HZ       = 700,
  parameter int DELAY_PERIODS = 350,
  parameter logic [15:0] REF_RATIO = 16'd1000,
  parameter logic [15:0] CMP_RATIO = 16'd59650
) (
  input  logic clk,
  input  logic rst,
  output logic ser_clk_o,
  output logic ser_data_o,
  output logic ser_le_o,
  output logic done_o
);
  localparam int HALF   = CLK_HZ / (2 * SCLK_HZ);
  localparam int HALF_P = (HALF < 1) ? 1 : HALF;
  localparam int CW     = $clog2(HALF_P + 1);
  localparam int DW     = $clog2(DELAY_PERIODS + 1) + 1;
  localparam logic [4:0] LAST = 5'd17;

  typedef enum logic [1:0] {S_WAIT, S_SEND, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] div_cnt;
  logic [DW-1:0] dly;
  logic [4:0]    slot;
  logic          phase, frame, data_r, le_r, done_r;
  logic          tick, fall;

  function automatic logic pick(input logic f, input logic [4:0] s);
    logic [15:0] r;
    r = f ? CMP_RATIO : REF_RATIO;
    if (s < 5'd16)       return r[4'd15 - s[3:0]];
    else if (s == 5'd16) return ~f;
    else                 return 1'b0;
  endfunction

  assign tick = (div_cnt == CW'(HALF_P - 1));
  assign fall = tick && phase && (st != S_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      phase   <= 1'b0;
      st      <= S_WAIT;
      dly     <= '0;
      slot    <= '0;
      frame   <= 1'b0;
      data_r  <= 1'b0;
      le_r    <= 1'b0;
      done_r  <= 1'b0;
    end else begin
      if (st != S_DONE) begin
        if (tick) begin
          div_cnt <= '0;
          phase   <= ~phase;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
      if (fall) begin
        case (st)
          S_WAIT: begin
            if (dly == DW'(DELAY_PERIODS)) begin
              st     <= S_SEND;
              slot   <= '0;
              frame  <= 1'b0;
              data_r <= pick(1'b0, 5'd0);
              le_r   <= 1'b0;
            end else begin
              dly <= dly + 1'b1;
            end
          end
          S_SEND: begin
            if (slot == LAST) begin
              le_r <= 1'b0;
              if (frame) begin
                st     <= S_DONE;
                data_r <= 1'b0;
                done_r <= 1'b1;
              end else begin
                frame  <= 1'b1;
                slot   <= '0;
                data_r <= pick(1'b1, 5'd0);
              end
            end else begin
              slot   <= slot + 1'b1;
              data_r <= pick(frame, slot + 1'b1);
              le_r   <= (slot + 1'b1 == LAST);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ser_clk_o  = phase && (st == S_SEND);
  assign ser_data_o = data_r;
  assign ser_le_o   = le_r;
  assign done_o     = done_r;

  assert_data_steady_R8: assert property (@(posedge clk) disable iff (rst)
    ser_clk_o |=> (!ser_clk_o || ($stable(ser_data_o) && $stable(ser_le_o))));

  assert_le_data_low_R6: assert property (@(posedge clk) disable iff (rst)
    ser_le_o |-> !ser_data_o);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o && !ser_clk_o && !ser_le_o && !ser_data_o));

  assert_no_clock_waiting_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT) |-> (!ser_clk_o && !ser_le_o));

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!ser_clk_o && !ser_data_o && !ser_le_o && !done_o));
endmodule

// File: tb/test_syn_div_loader.sv
module test_syn_div_loader;
  localparam int H = 5;
  localparam int D = 2;
  localparam logic [15:0] REFV = 16'd1000;
  localparam logic [15:0] CMPV = 16'd59650;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk, sdata, sle, done;
  int total = 0, bad = 0;
  int edges = 0;
  logic [1:0] q[$];
  int idx = 0;
  int last_rise = -1;
  logic prev_sclk = 1'b0;
  bit expect_first = 1'b0;

  always #10 clk = ~clk;

  syn_div_loader #(.CLK_HZ(1000), .SCLK_HZ(100), .DELAY_PERIODS(D),
                   .REF_RATIO(REFV), .CMP_RATIO(CMPV)) i_syn_div_loader (
    .clk(clk), .rst(rst), .ser_clk_o(sclk), .ser_data_o(sdata),
    .ser_le_o(sle), .done_o(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_frame(input logic [15:0] r, input logic ctl);
    for (int b = 15; b >= 0; b--) q.push_back({1'b0, r[b]});
    q.push_back({1'b0, ctl});
    q.push_back(2'b10);
  endtask

  always @(posedge clk) if (rst) edges <= 0; else edges <= edges + 1;

  always @(negedge clk) begin
    if (rst) begin
      prev_sclk <= 1'b0;
      last_rise <= -1;
    end else begin
      prev_sclk <= sclk;
      if (sclk && !prev_sclk) begin
        if (expect_first) begin
          check(edges == (2*D+3)*H, "R2", edges, (2*D+3)*H);
          expect_first = 1'b0;
        end
        if (last_rise >= 0) check(edges - last_rise == 2*H, "R3", edges - last_rise, 2*H);
        last_rise <= edges;
        if (q.size() == 0) begin
          check(1'b0, "R9", 1, 0);
        end else begin
          automatic logic [1:0] e = q.pop_front();
          automatic int s = idx % 18;
          automatic string req = (s < 16) ? ((idx >= 18) ? "R7" : "R4") :
                                 (s == 16) ? "R5" : "R6";
          check({sle, sdata} == e, req, {sle, sdata}, e);
          idx++;
        end
      end
    end
  end

  task automatic run_once(input string rq);
    idx = 0;
    push_frame(REFV, 1'b1);
    push_frame(CMPV, 1'b0);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!sclk && !sdata && !sle && !done, "R1", {sclk, sdata, sle, done}, 0);
    expect_first = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    check(!sclk && !sdata && !sle && !done, "R1", {sclk, sdata, sle, done}, 0);
    wait (done);
    repeat (20 * H) @(negedge clk);
    check(q.size() == 0, rq, q.size(), 0);
    check(idx == 36, rq, idx, 36);
    check(done && !sclk && !sdata && !sle, "R9", {done, sclk, sdata, sle}, 8);
  endtask

  initial begin
    run_once("R9");
    run_once("R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule